// File: doc/BRIEF.md
# NOR Flash Bank Identification Probe

This block sits on the controller side of a parallel NOR flash bank and works out which part is attached. It leaves reset with a probe already pending, and software or other logic can ask for another probe at any time through a request pulse. The block masters a simple synchronous word-addressed memory bus. It writes the autoselect unlock sequence, reads the manufacturer and device codes, and sorts the part into one of two command families. It then reports the sector count and bank size and puts the bank back into read mode with the command that family expects.

Once a probe has finished, a combinational query port turns a sector index into the sector's byte start address. It handles both the uniform-sector map and the bottom-boot map, in which the first eight sectors are small. The bus is either 16 bits wide with one device, or 32 bits wide with two 16-bit devices side by side. On the wider bus every command is written to both halves, and every size, sector size and address stride doubles. Read data on the bus is registered: data for a read strobed in one cycle is presented in the next cycle.

Top module: `nor_id_probe`

## Requirements
- R1: A probe writes exactly three commands, in this order: data 0xAA at word address 0x555, data 0x55 at word address 0x2AA, and data 0x90 at word address 0x555. Each command byte is placed zero-extended in every 16-bit lane (0x00AA00AA on a 32-bit bus). Write and read strobes are never active together.
- R2: The manufacturer code is bits [7:0] of the word read at word address 0, and all other bits of that word are ignored. Code 0x01 selects the unlock-cycle family, reported as family 1. Code 0x89 selects the status-register family, reported as family 2. Any other code reports "not valid" with family 0, sector count 0 and bank size 0.
- R3: The device code is the whole word read at word address 1. Every 16-bit lane must hold the same code, and the code is taken into account only when the manufacturer code is recognised. The recognised codes are: 0x22D7 (uniform), 0x88C1 and 0x8893 (8 Mbit), 0x88C3 and 0x8891 (16 Mbit), 0x88C5 and 0x8897 (32 Mbit), 0x88CD and 0x8899 (64 Mbit). Any other code, or lanes that differ, reports "not valid" with zero count and size.
- R4: The uniform code reports 128 sectors, boot_map 0 and 8 MB per device. The 8, 16, 32 and 64 Mbit codes report 23, 39, 71 and 135 sectors and 1, 2, 4 and 8 MB per device, with boot_map 1. bank_bytes is the per-device size multiplied by the number of 16-bit lanes.
- R5: After a valid identification, one write goes to word address 0: 0xF0 in each lane for family 1, or 0xFF in each lane for family 2. After a probe that is not valid, no such write is made.
- R6: On a boot map, sector i below 8 starts at BASE + i x 8 KB x lanes. Sector i of 8 or more starts at BASE + (i - 7) x 64 KB x lanes.
- R7: On a uniform map, sector i starts at BASE + i x 64 KB x lanes. q_hit is 1 only when the result is valid and q_index is less than sect_count.
- R8: While reset is held, the bus strobes, probe_done, id_valid, sect_count and bank_bytes are all 0. A probe starts by itself after reset without any request.
- R9: probe_done is a one-cycle pulse, and the result outputs change only in the cycle in which it is high. A probe_req that arrives while a probe is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_req | input | 1 | Start a probe when idle |
| bus_addr | output | ADDR_W | Word address to the flash bank |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe; data is returned the next cycle |
| bus_rdata | input | DATA_W | Read data |
| probe_done | output | 1 | One-cycle completion pulse |
| id_valid | output | 1 | Part recognised |
| id_family | output | 2 | 0 none, 1 unlock-cycle, 2 status-register |
| boot_map | output | 1 | Bottom-boot sector map |
| sect_count | output | 8 | Number of sectors |
| bank_bytes | output | 32 | Bank size in bytes |
| q_index | input | 8 | Sector index to look up |
| q_addr | output | 32 | Sector start byte address |
| q_hit | output | 1 | Index lies inside the bank |

## Verification
Two things can happen in the same cycle. A second request can arrive while the command sequence is still running, and the result registers can load in the same cycle that the sector query port is being read. The bench raises probe_req a second time in the middle of a probe and counts probe_done pulses over a long window afterwards, where exactly one pulse is the correct outcome. It also holds a query index steady across a reprobe of a different part and checks that q_addr follows the new map only after the done pulse.

// File: rtl/nid_pkg.sv
package nid_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_AUTO, ST_RD0, ST_RD1, ST_CAP, ST_EXIT
  } seq_st_t;

  localparam logic [1:0] FAM_NONE   = 2'd0;
  localparam logic [1:0] FAM_UNLOCK = 2'd1;
  localparam logic [1:0] FAM_STATUS = 2'd2;

  localparam logic [7:0] MFR_UNLOCK = 8'h01;
  localparam logic [7:0] MFR_STATUS = 8'h89;

  localparam logic [15:0] DEV_UNIFORM = 16'h22D7;
  localparam logic [15:0] DEV_B8_A    = 16'h88C1;
  localparam logic [15:0] DEV_B8_B    = 16'h8893;
  localparam logic [15:0] DEV_B16_A   = 16'h88C3;
  localparam logic [15:0] DEV_B16_B   = 16'h8891;
  localparam logic [15:0] DEV_B32_A   = 16'h88C5;
  localparam logic [15:0] DEV_B32_B   = 16'h8897;
  localparam logic [15:0] DEV_B64_A   = 16'h88CD;
  localparam logic [15:0] DEV_B64_B   = 16'h8899;

  localparam logic [7:0] CMD_UNL1     = 8'hAA;
  localparam logic [7:0] CMD_UNL2     = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL  = 8'h90;
  localparam logic [7:0] CMD_RD_UNL   = 8'hF0;
  localparam logic [7:0] CMD_RD_STS   = 8'hFF;
endpackage

// File: rtl/nid_classify.sv
module nid_classify
  import nid_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        mfr_code,
  input  logic [DATA_W-1:0] dev_word,
  output logic              known,
  output logic [1:0]        family,
  output logic              boot,
  output logic [7:0]        count,
  output logic [31:0]       dev_bytes
);
  localparam int LANES = DATA_W / 16;

  logic [LANES-1:0] lane_eq;
  logic [1:0]       fam_m;
  logic             geo_hit;
  logic             geo_boot;
  logic [7:0]       geo_cnt;
  logic [31:0]      geo_bytes;

  assign lane_eq[0] = 1'b1;
  for (genvar g = 1; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (dev_word[g*16 +: 16] == dev_word[15:0]);
  end

  always_comb begin
    case (mfr_code)
      MFR_UNLOCK: fam_m = FAM_UNLOCK;
      MFR_STATUS: fam_m = FAM_STATUS;
      default:    fam_m = FAM_NONE;
    endcase
  end

  always_comb begin
    geo_hit   = 1'b1;
    geo_boot  = 1'b1;
    geo_cnt   = 8'd0;
    geo_bytes = 32'd0;
    case (dev_word[15:0])
      DEV_UNIFORM: begin geo_boot = 1'b0; geo_cnt = 8'd128; geo_bytes = 32'h0080_0000; end
      DEV_B8_A, DEV_B8_B:   begin geo_cnt = 8'd23;  geo_bytes = 32'h0010_0000; end
      DEV_B16_A, DEV_B16_B: begin geo_cnt = 8'd39;  geo_bytes = 32'h0020_0000; end
      DEV_B32_A, DEV_B32_B: begin geo_cnt = 8'd71;  geo_bytes = 32'h0040_0000; end
      DEV_B64_A, DEV_B64_B: begin geo_cnt = 8'd135; geo_bytes = 32'h0080_0000; end
      default: begin geo_hit = 1'b0; geo_boot = 1'b0; end
    endcase
  end

  always_comb begin
    known     = (fam_m != FAM_NONE) && geo_hit && (&lane_eq);
    family    = known ? fam_m : FAM_NONE;
    boot      = known && geo_boot;
    count     = known ? geo_cnt : 8'd0;
    dev_bytes = known ? geo_bytes : 32'd0;
  end
endmodule

// File: rtl/nid_seq.sv
module nid_seq
  import nid_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              known,
  input  logic [1:0]        family,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [7:0]        mfr_q,
  output logic [DATA_W-1:0] dev_q,
  output logic              load_en,
  output logic              done
);
  localparam int LANES = DATA_W / 16;
  localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'(12'h2AA);

  seq_st_t st_q, st_d;
  logic    pend_q;
  logic    done_q;

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    logic [DATA_W-1:0] w;
    for (int l = 0; l < LANES; l++) w[l*16 +: 16] = {8'h00, b};
    return w;
  endfunction

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (pend_q || start_req) st_d = ST_UNL1;
      ST_UNL1: st_d = ST_UNL2;
      ST_UNL2: st_d = ST_AUTO;
      ST_AUTO: st_d = ST_RD0;
      ST_RD0:  st_d = ST_RD1;
      ST_RD1:  st_d = ST_CAP;
      ST_CAP:  st_d = ST_EXIT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_EXIT);
      if (st_q == ST_UNL1) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mfr_q <= 8'd0;
      dev_q <= '0;
    end else begin
      if (st_q == ST_RD1) mfr_q <= bus_rdata[7:0];
      if (st_q == ST_CAP) dev_q <= bus_rdata;
    end
  end

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    case (st_q)
      ST_UNL1: begin bus_we = 1'b1; bus_addr = OFS_A; bus_wdata = rep(CMD_UNL1); end
      ST_UNL2: begin bus_we = 1'b1; bus_addr = OFS_B; bus_wdata = rep(CMD_UNL2); end
      ST_AUTO: begin bus_we = 1'b1; bus_addr = OFS_A; bus_wdata = rep(CMD_AUTOSEL); end
      ST_RD0:  begin bus_re = 1'b1; end
      ST_RD1:  begin bus_re = 1'b1; bus_addr = ADDR_W'(1); end
      ST_EXIT: begin
        bus_we    = known;
        bus_wdata = (family == FAM_STATUS) ? rep(CMD_RD_STS) : rep(CMD_RD_UNL);
      end
      default: ;
    endcase
  end

  assign load_en = (st_q == ST_EXIT);
  assign done    = done_q;
endmodule

// File: rtl/nid_secmap.sv
module nid_secmap #(
  parameter logic [31:0] BASE     = 32'h2000_0000,
  parameter int          SCALE_SH = 1
) (
  input  logic        valid,
  input  logic        boot,
  input  logic [7:0]  count,
  input  logic [7:0]  idx,
  output logic [31:0] addr,
  output logic        hit
);
  localparam int MAIN_SH  = 16 + SCALE_SH;
  localparam int SMALL_SH = 13 + SCALE_SH;

  logic [31:0] idx_w;
  logic [31:0] off;

  assign idx_w = {24'd0, idx};

  always_comb begin
    if (!valid)
      off = 32'd0;
    else if (boot && idx < 8'd8)
      off = idx_w << SMALL_SH;
    else if (boot)
      off = (idx_w - 32'd7) << MAIN_SH;
    else
      off = idx_w << MAIN_SH;
  end

  assign addr = BASE + off;
  assign hit  = valid && (idx < count);
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nid_pkg::*;
#(
  parameter int          ADDR_W = 22,
  parameter int          DATA_W = 32,
  parameter logic [31:0] BASE   = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              probe_done,
  output logic              id_valid,
  output logic [1:0]        id_family,
  output logic              boot_map,
  output logic [7:0]        sect_count,
  output logic [31:0]       bank_bytes,
  input  logic [7:0]        q_index,
  output logic [31:0]       q_addr,
  output logic              q_hit
);
  localparam int SCALE_SH = (DATA_W > 16) ? 1 : 0;

  logic [7:0]        mfr_q;
  logic [DATA_W-1:0] dev_q;
  logic              load_en;
  logic              c_known, c_boot;
  logic [1:0]        c_fam;
  logic [7:0]        c_cnt;
  logic [31:0]       c_bytes;

  nid_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(probe_req),
    .known(c_known), .family(c_fam),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .mfr_q(mfr_q), .dev_q(dev_q),
    .load_en(load_en), .done(probe_done)
  );

  nid_classify #(.DATA_W(DATA_W)) u_cls (
    .mfr_code(mfr_q), .dev_word(dev_q), .known(c_known), .family(c_fam),
    .boot(c_boot), .count(c_cnt), .dev_bytes(c_bytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid   <= 1'b0;
      id_family  <= FAM_NONE;
      boot_map   <= 1'b0;
      sect_count <= 8'd0;
      bank_bytes <= 32'd0;
    end else if (load_en) begin
      id_valid   <= c_known;
      id_family  <= c_fam;
      boot_map   <= c_boot;
      sect_count <= c_cnt;
      bank_bytes <= c_bytes << SCALE_SH;
    end
  end

  nid_secmap #(.BASE(BASE), .SCALE_SH(SCALE_SH)) u_map (
    .valid(id_valid), .boot(boot_map), .count(sect_count),
    .idx(q_index), .addr(q_addr), .hit(q_hit)
  );
endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              probe_done,
  input logic              id_valid,
  input logic              boot_map,
  input logic [7:0]        sect_count,
  input logic [31:0]       bank_bytes,
  input logic              q_hit
);
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  if (DATA_W > 16) begin : g_wide
    assert_lane_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> (bus_wdata[31:16] == bus_wdata[15:0]));
  end

  assert_unknown_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (sect_count == 8'd0 && bank_bytes == 32'd0));

  assert_uniform_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !boot_map) |-> (sect_count == 8'd128));

  assert_rdmode_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |-> (bus_wdata[7:4] == 4'hF));

  assert_hit_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> id_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done |=> !probe_done);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_done |-> ($stable(sect_count) && $stable(bank_bytes) && $stable(id_valid)));
endmodule

bind nor_id_probe nor_id_probe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .probe_done(probe_done), .id_valid(id_valid),
  .boot_map(boot_map), .sect_count(sect_count), .bank_bytes(bank_bytes), .q_hit(q_hit)
);

// File: tb/nor_id_probe_tb.sv
module nor_id_probe_tb;
  localparam logic [31:0] BASE = 32'h2000_0000;

  typedef struct packed {
    logic [31:0] mfr;
    logic [31:0] dev;
    logic        v;
    logic [1:0]  fam;
    logic        boot;
    logic [7:0]  cnt;
    logic [31:0] bytes;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0001_0001, 32'h22D7_22D7, 1'b1, 2'd1, 1'b0, 8'd128, 32'h0100_0000},
    '{32'h0089_0089, 32'h88C1_88C1, 1'b1, 2'd2, 1'b1, 8'd23,  32'h0020_0000},
    '{32'h0089_0089, 32'h8893_8893, 1'b1, 2'd2, 1'b1, 8'd23,  32'h0020_0000},
    '{32'h0089_0089, 32'h88C3_88C3, 1'b1, 2'd2, 1'b1, 8'd39,  32'h0040_0000},
    '{32'h0089_0089, 32'h8891_8891, 1'b1, 2'd2, 1'b1, 8'd39,  32'h0040_0000},
    '{32'h0089_0089, 32'h88C5_88C5, 1'b1, 2'd2, 1'b1, 8'd71,  32'h0080_0000},
    '{32'h0089_0089, 32'h8897_8897, 1'b1, 2'd2, 1'b1, 8'd71,  32'h0080_0000},
    '{32'h0089_0089, 32'h88CD_88CD, 1'b1, 2'd2, 1'b1, 8'd135, 32'h0100_0000},
    '{32'h0089_0089, 32'h8899_8899, 1'b1, 2'd2, 1'b1, 8'd135, 32'h0100_0000},
    '{32'h0077_0077, 32'h22D7_22D7, 1'b0, 2'd0, 1'b0, 8'd0,   32'h0},
    '{32'h0001_0001, 32'h1234_1234, 1'b0, 2'd0, 1'b0, 8'd0,   32'h0},
    '{32'hAB01_AB01, 32'h22D7_22D7, 1'b1, 2'd1, 1'b0, 8'd128, 32'h0100_0000},
    '{32'h0001_0001, 32'h22D7_88C1, 1'b0, 2'd0, 1'b0, 8'd0,   32'h0},
    '{32'h0089_0089, 32'h22D7_22D7, 1'b1, 2'd2, 1'b0, 8'd128, 32'h0100_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        probe_req = 1'b0;
  logic [21:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic        probe_done, id_valid, boot_map, q_hit;
  logic [1:0]  id_family;
  logic [7:0]  sect_count;
  logic [31:0] bank_bytes, q_addr;
  logic [7:0]  q_index = 8'd0;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;

  always #4 clk = ~clk;

  nor_id_probe u_dut (
    .clk(clk), .rst_n(rst_n), .probe_req(probe_req),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .probe_done(probe_done), .id_valid(id_valid),
    .id_family(id_family), .boot_map(boot_map), .sect_count(sect_count),
    .bank_bytes(bank_bytes), .q_index(q_index), .q_addr(q_addr), .q_hit(q_hit)
  );

  // behavioural flash bank: two 16-bit devices side by side
  logic [31:0] mdl_mfr = 32'h0001_0001;
  logic [31:0] mdl_dev = 32'h22D7_22D7;
  logic        autosel;
  logic [21:0] log_a [64];
  logic [31:0] log_d [64];
  int          wr_n;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autosel   <= 1'b0;
      wr_n      <= 0;
      bus_rdata <= 32'hFFFF_FFFF;
    end else begin
      if (bus_we) begin
        log_a[wr_n % 64] <= bus_addr;
        log_d[wr_n % 64] <= bus_wdata;
        wr_n <= wr_n + 1;
        if (bus_addr == 22'h555 && bus_wdata == 32'h0090_0090) autosel <= 1'b1;
        else if (bus_wdata == 32'h00F0_00F0 || bus_wdata == 32'h00FF_00FF) autosel <= 1'b0;
      end
      if (bus_re)
        bus_rdata <= !autosel ? 32'hFFFF_FFFF :
                     (bus_addr == 22'd0) ? mdl_mfr :
                     (bus_addr == 22'd1) ? mdl_dev : 32'hFFFF_FFFF;
    end
  end

  always @(negedge clk) if (rst_n && probe_done) done_cnt <= done_cnt + 1;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!probe_done && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) chk(1'b0, "R9 probe_done timeout", 32'd0, 32'd1);
  endtask

  task automatic pulse_req();
    @(negedge clk); probe_req = 1'b1;
    @(negedge clk); probe_req = 1'b0;
  endtask

  task automatic check_result(input vec_t v, input int base_n, input string lbl);
    chk(id_valid == v.v, {lbl, " R2/R3 id_valid"}, 32'(id_valid), 32'(v.v));
    chk(id_family == v.fam, {lbl, " R2 id_family"}, 32'(id_family), 32'(v.fam));
    chk(boot_map == v.boot, {lbl, " R4 boot_map"}, 32'(boot_map), 32'(v.boot));
    chk(sect_count == v.cnt, {lbl, " R4 sect_count"}, 32'(sect_count), 32'(v.cnt));
    chk(bank_bytes == v.bytes, {lbl, " R4 bank_bytes"}, bank_bytes, v.bytes);
    chk(wr_n - base_n == (v.v ? 4 : 3), {lbl, " R5 write count"}, 32'(wr_n - base_n), v.v ? 32'd4 : 32'd3);
    chk(log_a[base_n % 64] == 22'h555 && log_d[base_n % 64] == 32'h00AA_00AA,
        {lbl, " R1 first unlock"}, log_d[base_n % 64], 32'h00AA_00AA);
    chk(log_a[(base_n + 1) % 64] == 22'h2AA && log_d[(base_n + 1) % 64] == 32'h0055_0055,
        {lbl, " R1 second unlock"}, log_d[(base_n + 1) % 64], 32'h0055_0055);
    chk(log_a[(base_n + 2) % 64] == 22'h555 && log_d[(base_n + 2) % 64] == 32'h0090_0090,
        {lbl, " R1 autoselect"}, log_d[(base_n + 2) % 64], 32'h0090_0090);
    if (v.v) begin
      logic [31:0] cmd = (v.fam == 2'd2) ? 32'h00FF_00FF : 32'h00F0_00F0;
      chk(log_a[(base_n + 3) % 64] == 22'd0 && log_d[(base_n + 3) % 64] == cmd,
          {lbl, " R5 read-mode command"}, log_d[(base_n + 3) % 64], cmd);
    end
  endtask

  task automatic run_vec(input vec_t v, input string lbl);
    int b;
    mdl_mfr = v.mfr;
    mdl_dev = v.dev;
    b = wr_n;
    pulse_req();
    wait_done();
    @(negedge clk);
    check_result(v, b, lbl);
  endtask

  task automatic qchk(input logic [7:0] i, input logic [31:0] ea, input logic eh, input string tag);
    q_index = i;
    #1;
    chk(q_addr == ea, {tag, " q_addr"}, q_addr, ea);
    chk(q_hit == eh, {tag, " q_hit"}, 32'(q_hit), 32'(eh));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    logic [7:0]  hold_cnt;
    logic [31:0] hold_bytes;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(!bus_we && !bus_re, "R8 strobes in reset", {30'd0, bus_we, bus_re}, 32'd0);
    chk(!probe_done && !id_valid, "R8 done/valid in reset", {30'd0, probe_done, id_valid}, 32'd0);
    chk(sect_count == 0 && bank_bytes == 0, "R8 results in reset", bank_bytes, 32'd0);
    rst_n = 1'b1;
    // R8 automatic probe with no request
    wait_done();
    @(negedge clk);
    check_result(VEC[0], 0, "auto R8");

    // table of parts
    for (int k = 0; k < NV; k++) run_vec(VEC[k], $sformatf("vec%0d", k));

    // R6 boot map, 64 Mbit, 32-bit bus
    run_vec(VEC[7], "boot");
    qchk(8'd0,   BASE,                 1'b1, "R6 idx0");
    qchk(8'd3,   BASE + 32'h0000_C000, 1'b1, "R6 idx3");
    qchk(8'd7,   BASE + 32'h0001_C000, 1'b1, "R6 idx7");
    qchk(8'd8,   BASE + 32'h0002_0000, 1'b1, "R6 idx8");
    qchk(8'd134, BASE + 32'h00FE_0000, 1'b1, "R6 idx134");
    qchk(8'd135, BASE + 32'h0100_0000, 1'b0, "R7 idx135 outside");

    // query held across reprobe; R9 map changes only at done
    q_index = 8'd5;
    mdl_mfr = VEC[0].mfr;
    mdl_dev = VEC[0].dev;
    pulse_req();
    repeat (3) @(negedge clk);
    chk(q_addr == BASE + 32'h0001_4000, "R9 map held mid-probe", q_addr, BASE + 32'h0001_4000);
    wait_done();
    @(negedge clk);
    qchk(8'd5,   BASE + 32'h000A_0000, 1'b1, "R7 idx5");
    qchk(8'd127, BASE + 32'h00FE_0000, 1'b1, "R7 idx127");
    qchk(8'd128, BASE + 32'h0100_0000, 1'b0, "R7 idx128 outside");

    // R9 held results while model changes, no request
    hold_cnt = sect_count;
    hold_bytes = bank_bytes;
    mdl_dev = 32'h88C1_88C1;
    repeat (20) @(negedge clk);
    chk(sect_count == hold_cnt && bank_bytes == hold_bytes, "R9 results held", bank_bytes, hold_bytes);

    // R9 second request during a running probe is ignored
    d0 = done_cnt;
    pulse_req();
    @(negedge clk); probe_req = 1'b1;
    @(negedge clk); probe_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9 one done pulse", 32'(done_cnt - d0), 32'd1);
    chk(sect_count == 8'd23, "R9 reprobe result", 32'(sect_count), 32'd23);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule